// File: doc/BRIEF.md
# Prioritised Level Interrupt Controller

This block gathers up to 96 level-sensitive interrupt lines and presents one interrupt request to a processor. The lines are grouped into banks of 32. Each bank has a mask word, a set port and a clear port for that word, and a masked-pending view. Every line also has its own six-bit priority. A line competes for service only when three conditions hold: its level is high, it is unmasked, and its priority value is strictly below a global threshold. Among the lines that compete, the smallest priority value wins. When two lines have the same priority value, the lower line number wins.

The winning line number is captured when the request output rises. The processor reads the captured number from the sorted-number register. It then writes an acknowledge to the control register. The request output drops for at least one cycle, and arbitration runs again. Because the lines are levels, a line that is still high and still unmasked is picked again. If the captured line has fallen or has been masked by the time it is read, a spurious flag in the sorted word warns software. A soft-reset handshake returns all software state to its reset values over a fixed number of cycles. Plain storage is provided for the auto-idle, protection and idle settings, and a read-only revision word is readable.

All registers sit on a simple 32-bit bus with a byte address, a write strobe, write data and combinational read data.

Top module: `vic_top`

## Requirements
- R1: After reset the following hold. Every mask word (0x84, 0xA4, 0xC4) reads 0xFFFFFFFF. The threshold (0x68) reads 0xFF. Every priority register reads 0. Status bit 0 (0x14) reads 1. The sorted word (0x40) reads 0x80. `irqOut` is low.
- R2: Line n belongs to bank n>>5, at bit n%32. Bank b has four registers, each at the bank-0 address plus 0x20·b:
  - mask word at 0x84, where writing replaces the word;
  - clear port at 0x88, where each 1 bit unmasks its line;
  - set port at 0x8C, where each 1 bit masks its line;
  - masked-pending word at 0x98.
  Zero bits written to the set or clear port leave the mask unchanged.
- R3: The pending word of bank b reads the line levels ANDed with the inverse of that bank's mask.
- R4: The priority register of line n is at 0x100+4·n, with its value in bits 7:2. The eligible line with the smallest value wins. On equal values, the lowest line number wins.
- R5: A line is eligible only if its priority value is below the 8-bit threshold. A threshold of 0xFF therefore admits every priority.
- R6: When the controller is idle and any line is eligible, `irqOut` rises at the next clock edge. The winner's number is captured at that edge and appears in bits 6:0 of the sorted word.
- R7: Writing a word with bit 0 set to the control register (0x48) makes `irqOut` low after that edge. A new arbitration takes place at the following edge. A write with bit 0 clear has no effect.
- R8: The sorted word sets bit 7 in three cases: no request is active, the captured line's level is low, or the captured line is masked. In every case bits 6:0 keep the last captured number.
- R9: Writing configuration (0x10) with bit 1 set starts a soft reset. Status bit 0 reads 0 for 8 cycles while `irqOut` is held low. The mask, priority, threshold and configuration registers return to their R1 values, and status bit 0 then reads 1 again.
- R10: The following registers read back what was written: configuration bit 0 (auto-idle), protection bit 0 (0x4C) and idle bits 1:0 (0x50). The revision word at 0x00 reads 0x21 and ignores writes.
- R11: A line whose level stays high and stays unmasked is requested again after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, sampled at the rising clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| irqLevel | input | 96 | Level-sensitive interrupt lines |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The acknowledge write and a change of line levels can land on the same clock edge. This decides whether re-arbitration sees the old levels or the new ones.

The bench provokes this by raising a higher-priority line on exactly the cycle of the acknowledge write. It then expects `irqOut` to be low for one cycle, followed by a request carrying the new line's number.

Seeded random sets of levels, masks, priorities and thresholds are compared against a bench-computed winner.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  // Register addresses (software-visible, fixed)
  localparam int REG_REV     = 'h000;
  localparam int REG_CFG     = 'h010;
  localparam int REG_STAT    = 'h014;
  localparam int REG_SORT    = 'h040;
  localparam int REG_CTRL    = 'h048;
  localparam int REG_PROT    = 'h04C;
  localparam int REG_IDLE    = 'h050;
  localparam int REG_THR     = 'h068;
  localparam int BANK_BASE   = 'h080;
  localparam int BANK_STRIDE = 'h020;
  localparam int OFS_MASK    = 'h04;
  localparam int OFS_CLR     = 'h08;
  localparam int OFS_SET     = 'h0C;
  localparam int OFS_PEND    = 'h18;
  localparam int PRIO_BASE   = 'h100;
  localparam int PRIO_SHIFT  = 2;
  localparam int SPUR_BIT    = 7;

  // Strobes from control to datapath
  typedef struct packed {
    logic softClear;
    logic latchWinner;
    logic active;
  } vicStrobe_t;

endpackage

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC   = 96,
  parameter int PRIO_W    = 6,
  parameter int THR_W     = 8,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic [NUM_SRC-1:0] irqLevel,
  input  vicStrobe_t         strobe,
  input  logic               statusDone,
  output logic [DATA_W-1:0]  rdData,
  output logic               anyEligible
);

  localparam int BANK_W    = DATA_W;
  localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;
  localparam int FLAT_W    = NUM_BANKS * BANK_W;
  localparam int ID_W      = $clog2(NUM_SRC);

  logic [31:0]        addr32;
  logic [BANK_W-1:0]  maskQ [NUM_BANKS];
  logic [FLAT_W-1:0]  maskFlat;
  logic [FLAT_W-1:0]  levelFlat;

  assign addr32    = 32'(busAddr);
  assign levelFlat = FLAT_W'(irqLevel);

  // Per-bank mask word with direct, set and clear ports
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    localparam int BASE = BANK_BASE + b * BANK_STRIDE;
    logic wrHit, setHit, clrHit;
    assign wrHit  = busWrEn && (addr32 == BASE + OFS_MASK);
    assign setHit = busWrEn && (addr32 == BASE + OFS_SET);
    assign clrHit = busWrEn && (addr32 == BASE + OFS_CLR);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 maskQ[b] <= '1;
      else if (strobe.softClear) maskQ[b] <= '1;
      else if (wrHit)            maskQ[b] <= busWrData;
      else if (setHit)           maskQ[b] <= maskQ[b] | busWrData;
      else if (clrHit)           maskQ[b] <= maskQ[b] & ~busWrData;
    end

    assign maskFlat[b*BANK_W +: BANK_W] = maskQ[b];

    // R2: every 1 written to the set port leaves that line masked
    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rstN)
      (setHit && !strobe.softClear) |=> ((maskQ[b] & $past(busWrData)) == $past(busWrData)));
    // R2: every 1 written to the clear port leaves that line unmasked
    assert_mask_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
      (clrHit && !strobe.softClear) |=> ((maskQ[b] & $past(busWrData)) == '0));
  end

  // Priority registers
  logic [PRIO_W-1:0] prioQ [NUM_SRC];
  logic [31:0]       prioOfs;
  logic              prioHit;
  logic [ID_W-1:0]   prioIdx;

  assign prioOfs = addr32 - PRIO_BASE;
  assign prioHit = (addr32 >= PRIO_BASE) && (addr32 < PRIO_BASE + 4 * NUM_SRC)
                   && (addr32[1:0] == 2'b00);
  assign prioIdx = prioOfs[ID_W+1:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) prioQ[i] <= '0;
    end else if (strobe.softClear) begin
      for (int i = 0; i < NUM_SRC; i++) prioQ[i] <= '0;
    end else if (busWrEn && prioHit) begin
      prioQ[prioIdx] <= busWrData[PRIO_SHIFT +: PRIO_W];
    end
  end

  // Threshold and plain configuration storage
  logic [THR_W-1:0] thrQ;
  logic             autoIdleQ;
  logic             protQ;
  logic [1:0]       idleQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || strobe.softClear) begin
      thrQ      <= '1;
      autoIdleQ <= 1'b0;
      protQ     <= 1'b0;
      idleQ     <= '0;
    end else if (busWrEn) begin
      if (addr32 == REG_THR)  thrQ      <= busWrData[THR_W-1:0];
      if (addr32 == REG_CFG)  autoIdleQ <= busWrData[0];
      if (addr32 == REG_PROT) protQ     <= busWrData[0];
      if (addr32 == REG_IDLE) idleQ     <= busWrData[1:0];
    end
  end

  // Eligibility and linear priority search
  logic [NUM_SRC-1:0] eligible;
  logic [ID_W-1:0]    winIdx;
  logic [PRIO_W-1:0]  winPrio;
  logic               anyElig;

  always_comb begin
    winIdx  = '0;
    winPrio = '1;
    anyElig = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      eligible[i] = levelFlat[i] & ~maskFlat[i] & (THR_W'(prioQ[i]) < thrQ);
      if (eligible[i] && (!anyElig || prioQ[i] < winPrio)) begin
        winIdx  = ID_W'(i);
        winPrio = prioQ[i];
        anyElig = 1'b1;
      end
    end
  end

  assign anyEligible = anyElig;

  // Captured winner
  logic [ID_W-1:0] sortIdQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   sortIdQ <= '0;
    else if (strobe.softClear)   sortIdQ <= '0;
    else if (strobe.latchWinner) sortIdQ <= winIdx;
  end

  logic spurious;
  assign spurious = !strobe.active || !levelFlat[sortIdQ] || maskFlat[sortIdQ];

  // Read mux
  always_comb begin
    rdData = '0;
    if (addr32 == REG_REV)  rdData = 32'({4'(REV_MAJOR), 4'(REV_MINOR)});
    if (addr32 == REG_CFG)  rdData = 32'(autoIdleQ);
    if (addr32 == REG_STAT) rdData = 32'(statusDone);
    if (addr32 == REG_SORT) rdData = 32'(sortIdQ) | (32'(spurious) << SPUR_BIT);
    if (addr32 == REG_PROT) rdData = 32'(protQ);
    if (addr32 == REG_IDLE) rdData = 32'(idleQ);
    if (addr32 == REG_THR)  rdData = 32'(thrQ);
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr32 == BANK_BASE + b * BANK_STRIDE + OFS_MASK) rdData = maskQ[b];
      if (addr32 == BANK_BASE + b * BANK_STRIDE + OFS_PEND)
        rdData = levelFlat[b*BANK_W +: BANK_W] & ~maskQ[b];
    end
    if (prioHit) rdData = 32'(prioQ[prioIdx]) << PRIO_SHIFT;
  end

  // R4: the chosen line really competes
  assert_winner_eligible_R4: assert property (@(posedge clk) disable iff (!rstN)
    anyElig |-> eligible[winIdx]);
  // R5: the chosen line's priority lies below the threshold
  assert_winner_below_thr_R5: assert property (@(posedge clk) disable iff (!rstN)
    anyElig |-> (THR_W'(prioQ[winIdx]) < thrQ));
  // R6: captured number is a real line
  assert_sorted_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    32'(sortIdQ) < NUM_SRC);
  // R9: a soft-clear cycle leaves every line masked
  assert_clear_masks_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.softClear) |-> (maskFlat == '1));

endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              anyEligible,
  output vicStrobe_t        strobe,
  output logic              irqOut,
  output logic              statusDone
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACTIVE, ST_RESET} ctlState_t;

  ctlState_t        stateQ;
  logic [CNT_W-1:0] cntQ;
  logic             softReq;
  logic             ackReq;

  assign softReq = busWrEn && (32'(busAddr) == REG_CFG)  && busWrData[1];
  assign ackReq  = busWrEn && (32'(busAddr) == REG_CTRL) && busWrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else if (softReq) begin
      stateQ <= ST_RESET;
      cntQ   <= CNT_W'(RST_CYCLES - 1);
    end else begin
      unique case (stateQ)
        ST_IDLE:   if (anyEligible) stateQ <= ST_ACTIVE;
        ST_ACTIVE: if (ackReq)      stateQ <= ST_IDLE;
        ST_RESET: begin
          if (cntQ == '0) stateQ <= ST_IDLE;
          else            cntQ   <= cntQ - 1'b1;
        end
        default:   stateQ <= ST_IDLE;
      endcase
    end
  end

  assign strobe.softClear   = (stateQ == ST_RESET);
  assign strobe.latchWinner = (stateQ == ST_IDLE) && anyEligible && !softReq;
  assign strobe.active      = (stateQ == ST_ACTIVE);
  assign irqOut             = (stateQ == ST_ACTIVE);
  assign statusDone         = (stateQ != ST_RESET);

  // R6: a request only rises after a line was eligible
  assert_rise_needs_line_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(anyEligible));
  // R7: an acknowledge drops the request
  assert_ack_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && irqOut && !softReq) |=> !irqOut);
  // R9: soft reset makes the status busy
  assert_reset_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    softReq |=> !statusDone);
  // R9: no request during soft reset start
  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    softReq |=> !irqOut);

endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC    = 96,
  parameter int PRIO_W     = 6,
  parameter int THR_W      = 8,
  parameter int RST_CYCLES = 8,
  parameter int REV_MAJOR  = 2,
  parameter int REV_MINOR  = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [11:0]        busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  input  logic [NUM_SRC-1:0] irqLevel,
  output logic               irqOut
);

  vicStrobe_t strobe;
  logic       anyEligible;
  logic       statusDone;

  vic_control #(.RST_CYCLES(RST_CYCLES)) control_i (
    .clk         (clk),
    .rstN        (rstN),
    .busAddr     (busAddr),
    .busWrEn     (busWrEn),
    .busWrData   (busWrData),
    .anyEligible (anyEligible),
    .strobe      (strobe),
    .irqOut      (irqOut),
    .statusDone  (statusDone)
  );

  vic_datapath #(
    .NUM_SRC   (NUM_SRC),
    .PRIO_W    (PRIO_W),
    .THR_W     (THR_W),
    .REV_MAJOR (REV_MAJOR),
    .REV_MINOR (REV_MINOR)
  ) datapath_i (
    .clk         (clk),
    .rstN        (rstN),
    .busAddr     (busAddr),
    .busWrEn     (busWrEn),
    .busWrData   (busWrData),
    .irqLevel    (irqLevel),
    .strobe      (strobe),
    .statusDone  (statusDone),
    .rdData      (busRdData),
    .anyEligible (anyEligible)
  );

endmodule

// File: tb/vic_top_tb_top.sv
module vic_top_tb_top;

  localparam int NSRC = 96;
  localparam logic [11:0] A_REV = 12'h000, A_CFG = 12'h010, A_STAT = 12'h014,
                          A_SORT = 12'h040, A_CTRL = 12'h048, A_PROT = 12'h04C,
                          A_IDLE = 12'h050, A_THR = 12'h068;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [11:0]     busAddr = '0;
  logic            busWrEn = 1'b0;
  logic [31:0]     busWrData = '0;
  logic [31:0]     busRdData;
  logic [NSRC-1:0] irqLevel = '0;
  logic            irqOut;

  int checks = 0;
  int fails  = 0;

  bit mdlMask [NSRC];
  int mdlPrio [NSRC];
  int mdlThr;

  always #2 clk = ~clk;

  vic_top dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .irqLevel  (irqLevel),
    .irqOut    (irqOut)
  );

  function automatic logic [11:0] maskAddr(input int b, input int ofs);
    return 12'(32'h80 + b * 32'h20 + ofs);
  endfunction

  function automatic logic [11:0] prioAddr(input int n);
    return 12'(32'h100 + 4 * n);
  endfunction

  function automatic int modelWinner();
    int best = -1;
    int bp = 0;
    for (int i = 0; i < NSRC; i++) begin
      if (irqLevel[i] && !mdlMask[i] && mdlPrio[i] < mdlThr &&
          (best < 0 || mdlPrio[i] < bp)) begin
        best = i;
        bp = mdlPrio[i];
      end
    end
    return best;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    #1 d = busRdData;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1 check("R1 irqOut after reset", 32'(irqOut), 0);
    for (int b = 0; b < 3; b++) begin
      busRead(maskAddr(b, 4), rd); check("R1 mask word", rd, 32'hFFFF_FFFF);
    end
    busRead(A_THR, rd);        check("R1 threshold", rd, 32'hFF);
    busRead(prioAddr(5), rd);  check("R1 priority", rd, 0);
    busRead(A_STAT, rd);       check("R1 status", rd, 1);
    busRead(A_SORT, rd);       check("R1 sorted", rd, 32'h80);

    // R10 plain registers and revision
    busWrite(A_CFG, 32'h1);  busRead(A_CFG, rd);  check("R10 autoidle", rd, 1);
    busWrite(A_PROT, 32'h1); busRead(A_PROT, rd); check("R10 protection", rd, 1);
    busWrite(A_IDLE, 32'h3); busRead(A_IDLE, rd); check("R10 idle", rd, 3);
    busWrite(A_REV, 32'h0);  busRead(A_REV, rd);  check("R10 revision", rd, 32'h21);

    // R2 set/clear ports on bank 1
    busWrite(maskAddr(1, 8), 32'h5);  busRead(maskAddr(1, 4), rd);
    check("R2 clear port", rd, 32'hFFFF_FFFA);
    busWrite(maskAddr(1, 8), 32'h0);  busRead(maskAddr(1, 4), rd);
    check("R2 zero clear no effect", rd, 32'hFFFF_FFFA);
    busWrite(maskAddr(1, 12), 32'h1); busRead(maskAddr(1, 4), rd);
    check("R2 set port", rd, 32'hFFFF_FFFB);
    busWrite(maskAddr(1, 12), 32'h0); busRead(maskAddr(1, 4), rd);
    check("R2 zero set no effect", rd, 32'hFFFF_FFFB);

    // R3 pending view: line 34 unmasked, line 35 masked
    @(negedge clk); irqLevel[34] = 1'b1; irqLevel[35] = 1'b1;
    busRead(maskAddr(1, 24), rd); check("R3 pending bank1", rd, 32'h4);

    // R6 request and captured number
    check("R6 irqOut high", 32'(irqOut), 1);
    busRead(A_SORT, rd); check("R6 sorted number", rd, 34);

    // R7 zero write ignored, then acknowledge; R11 re-request
    busWrite(A_CTRL, 32'h0);
    #1 check("R7 zero ack ignored", 32'(irqOut), 1);
    busWrite(A_CTRL, 32'h1);
    #1 check("R7 ack drops irq", 32'(irqOut), 0);
    @(negedge clk); #1 check("R11 level re-requested", 32'(irqOut), 1);
    busRead(A_SORT, rd); check("R11 same number", rd, 34);

    // R8 spurious when line falls
    @(negedge clk); irqLevel[34] = 1'b0;
    #1 busAddr = A_SORT; #1 check("R8 spurious after fall", busRdData, 32'h80 | 34);
    busWrite(A_CTRL, 32'h1);
    @(negedge clk); #1 check("R8 no new request", 32'(irqOut), 0);
    busRead(A_SORT, rd); check("R8 idle keeps number", rd, 32'h80 | 34);

    // R4 priority then tie on 36 and 40
    busWrite(prioAddr(36), 32'hC);
    busRead(prioAddr(36), rd); check("R4 priority field", rd, 32'hC);
    busWrite(maskAddr(1, 8), (32'h1 << 4) | (32'h1 << 8));
    @(negedge clk); irqLevel[36] = 1'b1; irqLevel[40] = 1'b1;
    repeat (2) @(negedge clk);
    busRead(A_SORT, rd); check("R4 lower value wins", rd, 40);
    busWrite(A_CTRL, 32'h1);
    repeat (2) @(negedge clk);
    busRead(A_SORT, rd); check("R11 40 re-requested", rd, 40);
    busWrite(prioAddr(40), 32'hC);
    busWrite(A_CTRL, 32'h1);
    repeat (2) @(negedge clk);
    busRead(A_SORT, rd); check("R4 tie lowest number", rd, 36);

    // R5 threshold
    busWrite(A_THR, 32'h3);
    busWrite(A_CTRL, 32'h1);
    repeat (2) @(negedge clk);
    #1 check("R5 threshold blocks", 32'(irqOut), 0);
    busWrite(A_THR, 32'h4);
    repeat (2) @(negedge clk);
    #1 check("R5 threshold admits", 32'(irqOut), 1);
    busRead(A_SORT, rd); check("R5 winner", rd, 36);
    busWrite(A_THR, 32'hFF);

    // Same-cycle acknowledge and new higher-priority line (R7, R4)
    busWrite(prioAddr(70), 32'h4);
    busWrite(maskAddr(2, 8), 32'h1 << 6);
    @(negedge clk);
    irqLevel[70] = 1'b1; busAddr = A_CTRL; busWrData = 32'h1; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
    #1 check("R7 gap after ack", 32'(irqOut), 0);
    @(negedge clk); #1 check("R7 new request", 32'(irqOut), 1);
    busRead(A_SORT, rd); check("R4 new line wins", rd, 70);

    // R9 soft reset
    busWrite(A_CFG, 32'h3);
    #1 check("R9 irq low in reset", 32'(irqOut), 0);
    busRead(A_STAT, rd); check("R9 status busy", rd, 0);
    repeat (10) @(negedge clk);
    busRead(A_STAT, rd);         check("R9 status done", rd, 1);
    busRead(maskAddr(1, 4), rd); check("R9 mask restored", rd, 32'hFFFF_FFFF);
    busRead(prioAddr(70), rd);   check("R9 priority cleared", rd, 0);
    busRead(A_CFG, rd);          check("R9 config cleared", rd, 0);
    busRead(A_THR, rd);          check("R9 threshold restored", rd, 32'hFF);
    #1 check("R9 irq stays low", 32'(irqOut), 0);

    // Random: R4, R5, R6
    for (int it = 0; it < 25; it++) begin
      int w;
      int tsel;
      busWrite(A_THR, 32'h0);
      busWrite(A_CTRL, 32'h1);
      @(negedge clk);
      irqLevel = {$urandom & $urandom, $urandom & $urandom, $urandom & $urandom};
      for (int b = 0; b < 3; b++) begin
        logic [31:0] m;
        m = $urandom;
        busWrite(maskAddr(b, 4), m);
        for (int k = 0; k < 32; k++) mdlMask[b*32+k] = m[k];
      end
      for (int i = 0; i < NSRC; i++) begin
        mdlPrio[i] = int'($urandom_range(0, 3));
        busWrite(prioAddr(i), 32'(mdlPrio[i]) << 2);
      end
      tsel = int'($urandom_range(0, 4));
      mdlThr = (tsel == 4) ? 255 : tsel + 1;
      busWrite(A_THR, 32'(mdlThr));
      repeat (2) @(negedge clk);
      w = modelWinner();
      #1 check("R6 random request", 32'(irqOut), (w >= 0) ? 1 : 0);
      busRead(A_SORT, rd);
      if (w >= 0) check("R4 random winner", rd, 32'(w));
      else        check("R5 random none eligible", 32'(rd[7]), 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule